// File: doc/BRIEF.md
# SMBus Bus-State and Timeout Monitor

This block watches the two lines of an SMBus segment and turns long, abnormal line conditions into events for the transaction logic around it. It samples the clock and data lines with the system clock through a two-stage synchronizer. It measures how long each condition lasts by counting a periodic enable tick, so every duration limit is a whole number of ticks. Byte, address and packet-check decoding are done elsewhere.

Four conditions are timed. A clock line held low past the clock-low timeout gives a one-cycle abort pulse. With the default 10 µs tick the timeout is 30 ms, inside the permitted 25 ms to 35 ms window. Both lines held high past the idle limit give a one-cycle transaction-reset pulse. Both lines held low for the bus-off limit (2 s by default) raise a bus-off level. Both lines held low for the longer calibration limit (5 s by default) raise a calibration-request level. Both levels drop as soon as either line goes high. Bus-ready is low while the bus is off and stays low for a short recovery window after it leaves that state (1 ms by default). A disable input switches off the clock-low timeout only.

Each duration counter saturates at its limit, so one long condition produces exactly one event. A new event needs the condition to end and start again.

Top module: `smb_bus_watch`

## Requirements
- R1: After synchronization, `abort_o` pulses high for exactly one cycle when the clock line has been low for LOW_LIM ticks in a row. A low period shorter than LOW_LIM ticks gives no pulse. A longer low period still gives only one pulse.
- R2: While `tmo_disable_i` is 1, the clock-low timer is held at zero and `abort_o` stays 0. This input has no effect on the other conditions.
- R3: `idle_reset_o` pulses high for exactly one cycle when both lines have been high for IDLE_LIM ticks in a row. A shorter high period gives no pulse, and a longer one gives only one pulse.
- R4: `bus_off_o` goes to 1 in the cycle in which both lines have been low for OFF_LIM ticks. It returns to 0 as soon as the synchronized state shows either line high.
- R5: `cal_req_o` goes to 1 in the cycle in which both lines have been low for CAL_LIM ticks, with CAL_LIM at least OFF_LIM. It clears under the same rule as bus-off.
- R6: `bus_ready_o` is 0 while bus-off is set. After bus-off clears, it stays 0 for AVAIL_LIM ticks and then returns to 1.
- R7: Duration counters advance only in cycles where `tick_i` is 1, so every limit is counted in ticks and not in clock cycles.
- R8: In reset, and in the first cycle after it, `abort_o`, `idle_reset_o`, `bus_off_o` and `cal_req_o` are 0 and `bus_ready_o` is 1. The synchronizer resets to the idle-high line state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SMBus clock line, asynchronous |
| sda_i | input | 1 | SMBus data line, asynchronous |
| tmo_disable_i | input | 1 | 1 turns the clock-low timeout off |
| tick_i | input | 1 | Time-base enable; one tick is one duration unit |
| abort_o | output | 1 | One-cycle pulse on clock-low timeout |
| idle_reset_o | output | 1 | One-cycle pulse on long both-high idle |
| bus_off_o | output | 1 | Level: both lines low for the bus-off limit |
| cal_req_o | output | 1 | Level: both lines low for the calibration limit |
| bus_ready_o | output | 1 | Level: bus usable (not off and not recovering) |

## Verification
The embedded properties check the following on every cycle:
- abort and idle-reset are single-cycle pulses, and each one coincides with its counter reaching its limit;
- no abort appears while the timeout is disabled;
- bus-off is only ever set after a both-low sample;
- a calibration request never stands without bus-off;
- bus-ready is low in the cycle after bus-off falls;
- counters hold their value between ticks.

The exact tick counts at which each event fires or fails to fire, one below and at each limit, can only be shown by the bench's scenarios. The same holds for how long the recovery window lasts, the clearing of the levels when one line rises, the effect of a sparse tick, and a reset taken during bus-off.

// File: rtl/smb_watch_pkg.sv
package smb_watch_pkg;
    // Line pair carried through the synchronizer; idle bus is both high.
    typedef struct packed {
        logic scl;
        logic sda;
    } smb_lines_t;

    localparam int unsigned SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync
    import smb_watch_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_STAGES_DEF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  smb_lines_t raw_i,
    output smb_lines_t sync_o
);
    smb_lines_t [STAGES-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = raw_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '1;
        else        stage_q <= stage_d;
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/smb_sat_timer.sv
module smb_sat_timer #(
    parameter int unsigned LIMIT = 8,
    localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          tick_i,
    output logic [CW-1:0] count_o,
    output logic          reach_o
);
    localparam logic [CW-1:0] LAST = CW'(LIMIT);
    localparam logic [CW-1:0] PRE  = CW'(LIMIT - 1);

    typedef struct packed {
        logic [CW-1:0] count;
        logic          reach;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.reach = 1'b0;
        if (!run_i) begin
            st_d.count = '0;
        end else if (tick_i && st_q.count != LAST) begin
            st_d.count = st_q.count + 1'b1;
            st_d.reach = (st_q.count == PRE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;
    assign reach_o = st_q.reach;

    // R7
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_i) |=> $stable(count_o));

    // R1
    sat_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= LAST);
endmodule

// File: rtl/smb_bus_watch.sv
module smb_bus_watch
    import smb_watch_pkg::*;
#(
    parameter int unsigned LOW_LIM     = 3000,
    parameter int unsigned IDLE_LIM    = 5,
    parameter int unsigned OFF_LIM     = 200000,
    parameter int unsigned CAL_LIM     = 500000,
    parameter int unsigned AVAIL_LIM   = 100,
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic tmo_disable_i,
    input  logic tick_i,
    output logic abort_o,
    output logic idle_reset_o,
    output logic bus_off_o,
    output logic cal_req_o,
    output logic bus_ready_o
);
    localparam int unsigned LW = $clog2(LOW_LIM + 1);
    localparam int unsigned IW = $clog2(IDLE_LIM + 1);
    localparam int unsigned BW = $clog2(CAL_LIM + 1);
    localparam int unsigned RW = $clog2(AVAIL_LIM + 1);
    localparam logic [BW-1:0] OFF_AT  = BW'(OFF_LIM);
    localparam logic [BW-1:0] OFF_PRE = BW'(OFF_LIM - 1);
    localparam logic [BW-1:0] CAL_AT  = BW'(CAL_LIM);
    localparam logic [BW-1:0] CAL_PRE = BW'(CAL_LIM - 1);
    localparam logic [RW-1:0] REC_LOAD = RW'(AVAIL_LIM);

    smb_lines_t raw_lines, sync_lines;
    assign raw_lines.scl = scl_i;
    assign raw_lines.sda = sda_i;

    smb_line_sync #(.STAGES(SYNC_STAGES)) line_sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (raw_lines),
        .sync_o (sync_lines)
    );

    logic both_low, both_high, low_run;
    assign both_low  = !sync_lines.scl && !sync_lines.sda;
    assign both_high =  sync_lines.scl &&  sync_lines.sda;
    assign low_run   = !sync_lines.scl && !tmo_disable_i;

    logic [LW-1:0] low_cnt;
    logic [IW-1:0] idle_cnt;
    logic [BW-1:0] bl_cnt;
    logic          bl_reach;

    smb_sat_timer #(.LIMIT(LOW_LIM)) low_tmr_i (
        .clk(clk), .rst_n(rst_n), .run_i(low_run), .tick_i(tick_i),
        .count_o(low_cnt), .reach_o(abort_o)
    );

    smb_sat_timer #(.LIMIT(IDLE_LIM)) idle_tmr_i (
        .clk(clk), .rst_n(rst_n), .run_i(both_high), .tick_i(tick_i),
        .count_o(idle_cnt), .reach_o(idle_reset_o)
    );

    smb_sat_timer #(.LIMIT(CAL_LIM)) bl_tmr_i (
        .clk(clk), .rst_n(rst_n), .run_i(both_low), .tick_i(tick_i),
        .count_o(bl_cnt), .reach_o(bl_reach)
    );

    typedef struct packed {
        logic          bus_off;
        logic          cal;
        logic [RW-1:0] rec;
    } watch_state_t;

    watch_state_t ws_d, ws_q;

    always_comb begin
        ws_d = ws_q;
        // Levels follow the both-low counter's next value.
        ws_d.bus_off = both_low &&
                       (bl_cnt >= OFF_AT || (tick_i && bl_cnt == OFF_PRE));
        ws_d.cal     = both_low &&
                       (bl_cnt == CAL_AT || (tick_i && bl_cnt == CAL_PRE));
        if (ws_d.bus_off) begin
            ws_d.rec = '0;
        end else if (ws_q.bus_off) begin
            ws_d.rec = REC_LOAD;
        end else if (tick_i && ws_q.rec != '0) begin
            ws_d.rec = ws_q.rec - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ws_q <= '0;
        else        ws_q <= ws_d;
    end

    assign bus_off_o   = ws_q.bus_off;
    assign cal_req_o   = ws_q.cal;
    assign bus_ready_o = !ws_q.bus_off && (ws_q.rec == '0);

    // R1
    abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !abort_o);

    // R1
    abort_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> (low_cnt == LW'(LOW_LIM)));

    // R2
    abort_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tmo_disable_i) |-> !abort_o);

    // R3
    idle_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_reset_o |-> (idle_cnt == IW'(IDLE_LIM) && !$past(idle_reset_o)));

    // R4
    off_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_off_o |-> $past(both_low));

    // R5
    cal_within_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_req_o |-> bus_off_o);

    // R5
    cal_on_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bl_reach |-> cal_req_o);

    // R6
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_off_o) |-> !bus_ready_o);
endmodule

// File: tb/smb_bus_watch_tb.sv
module smb_bus_watch_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int P_LOW   = 20;
    localparam int P_IDLE  = 6;
    localparam int P_OFF   = 40;
    localparam int P_CAL   = 70;
    localparam int P_AVAIL = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda = 1'b1, dis = 1'b0, tick = 1'b1;
    logic abort_w, idle_w, off_w, cal_w, ready_w;

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_bus_watch #(
        .LOW_LIM(P_LOW), .IDLE_LIM(P_IDLE), .OFF_LIM(P_OFF),
        .CAL_LIM(P_CAL), .AVAIL_LIM(P_AVAIL)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .tmo_disable_i(dis), .tick_i(tick),
        .abort_o(abort_w), .idle_reset_o(idle_w), .bus_off_o(off_w),
        .cal_req_o(cal_w), .bus_ready_o(ready_w)
    );

    int n_cmp = 0, n_bad = 0;
    int n_abort = 0, n_idle = 0;
    logic seen_off = 1'b0, seen_cal = 1'b0;
    int tick_every = 1;
    int tick_ph = 0;
    logic done = 1'b0;

    // Time base: one tick every tick_every cycles.
    always @(negedge clk) begin
        if (tick_every <= 1) tick = 1'b1;
        else begin
            tick = (tick_ph == 0);
            tick_ph = (tick_ph + 1) % tick_every;
        end
    end

    // Output monitor, sampled a quarter period after the active edge.
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (abort_w) n_abort++;
        if (idle_w)  n_idle++;
        if (off_w)   seen_off = 1'b1;
        if (cal_w)   seen_cal = 1'b1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic lines(input logic s, input logic d, input logic t);
        scl = s; sda = d; dis = t;
    endtask

    task automatic clear_mon();
        n_abort = 0; n_idle = 0; seen_off = 1'b0; seen_cal = 1'b0;
    endtask

    typedef struct packed {
        logic       scl;
        logic       sda;
        logic       dis;
        logic [7:0] dur;
        logic [1:0] e_abort;
        logic [1:0] e_idle;
        logic       e_off;
        logic       e_cal;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b1, 1'b0, 8'd19, 2'd0, 2'd0, 1'b0, 1'b0}, // R1 below limit
        '{1'b0, 1'b1, 1'b0, 8'd20, 2'd1, 2'd0, 1'b0, 1'b0}, // R1 at limit
        '{1'b0, 1'b1, 1'b0, 8'd60, 2'd1, 2'd0, 1'b0, 1'b0}, // R1 saturation
        '{1'b0, 1'b1, 1'b1, 8'd60, 2'd0, 2'd0, 1'b0, 1'b0}, // R2 disabled
        '{1'b0, 1'b0, 1'b0, 8'd39, 2'd1, 2'd0, 1'b0, 1'b0}, // R4 below
        '{1'b0, 1'b0, 1'b0, 8'd40, 2'd1, 2'd0, 1'b1, 1'b0}, // R4 at limit
        '{1'b0, 1'b0, 1'b0, 8'd69, 2'd1, 2'd0, 1'b1, 1'b0}, // R5 below
        '{1'b0, 1'b0, 1'b0, 8'd70, 2'd1, 2'd0, 1'b1, 1'b1}, // R5 at limit
        '{1'b1, 1'b1, 1'b0, 8'd5,  2'd0, 2'd0, 1'b0, 1'b0}, // R3 below
        '{1'b1, 1'b1, 1'b0, 8'd6,  2'd0, 2'd1, 1'b0, 1'b0}, // R3 at limit
        '{1'b1, 1'b1, 1'b0, 8'd40, 2'd0, 2'd1, 1'b0, 1'b0}, // R3 saturation
        '{1'b1, 1'b1, 1'b1, 8'd40, 2'd0, 2'd1, 1'b0, 1'b0}  // R2 no effect on idle
    };

    // Pattern, then a neutral gap (clock high, data low) that times nothing.
    task automatic run_pat(input logic s, input logic d, input logic t, input int dur);
        clear_mon();
        lines(s, d, t);
        repeat (dur) @(negedge clk);
        lines(1'b1, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 reset abort", abort_w, 0);
        chk("R8 reset idle", idle_w, 0);
        chk("R8 reset bus_off", off_w, 0);
        chk("R8 reset cal", cal_w, 0);
        chk("R8 reset ready", ready_w, 1);
        lines(1'b1, 1'b0, 1'b0);
        repeat (20) @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            run_pat(VECS[v].scl, VECS[v].sda, VECS[v].dis, int'(VECS[v].dur));
            chk($sformatf("R1/R2 abort count vec %0d", v), n_abort, int'(VECS[v].e_abort));
            chk($sformatf("R3 idle count vec %0d", v), n_idle, int'(VECS[v].e_idle));
            chk($sformatf("R4 bus_off vec %0d", v), seen_off, VECS[v].e_off);
            chk($sformatf("R5 cal_req vec %0d", v), seen_cal, VECS[v].e_cal);
        end
        repeat (20) @(negedge clk);

        // R6: recovery window after bus-off
        lines(1'b0, 1'b0, 1'b0);
        repeat (50) @(negedge clk);
        chk("R4 bus_off held", off_w, 1);
        chk("R6 ready low in bus_off", ready_w, 0);
        lines(1'b1, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        chk("R4 bus_off clears on scl high", off_w, 0);
        chk("R6 ready low just after exit", ready_w, 0);
        repeat (P_AVAIL - 2) @(negedge clk);
        chk("R6 ready still low in window", ready_w, 0);
        repeat (3) @(negedge clk);
        chk("R6 ready back high", ready_w, 1);

        // R5: cal and bus_off clear when data alone rises
        lines(1'b0, 1'b0, 1'b0);
        repeat (80) @(negedge clk);
        chk("R5 cal set", cal_w, 1);
        lines(1'b0, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        chk("R5 cal clears on sda high", cal_w, 0);
        chk("R4 bus_off clears on sda high", off_w, 0);
        lines(1'b1, 1'b0, 1'b0);
        repeat (20) @(negedge clk);

        // R7: limits are counted in ticks, not cycles
        tick_every = 3;
        run_pat(1'b0, 1'b1, 1'b0, 45);
        chk("R7 sparse tick 15 ticks no abort", n_abort, 0);
        run_pat(1'b0, 1'b1, 1'b0, 75);
        chk("R7 sparse tick 25 ticks abort", n_abort, 1);
        tick_every = 1;
        repeat (5) @(negedge clk);

        // R8: reset taken during bus-off
        lines(1'b0, 1'b0, 1'b0);
        repeat (50) @(negedge clk);
        chk("R8 pre-reset bus_off", off_w, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 bus_off in reset", off_w, 0);
        chk("R8 ready in reset", ready_w, 1);
        lines(1'b1, 1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule